// File: doc/BRIEF.md
# Machine-Level Control Register Access Unit

This block carries out the read-and-modify instructions that operate on a small set of machine-level control registers. A core's execute stage presents one access at a time: a 12-bit register address, an operation code, a source that comes from a general register or from a 5-bit immediate, the index field of that source, the current privilege level and the raw instruction word. One clock later the unit returns the value the register held before the access, together with a write-back enable for the destination. If the access is not allowed it instead raises an illegal-instruction flag and returns the instruction word as trap information.

Seven registers are stored, each 64 bits wide: status, exception delegation, trap vector base, scratch, exception PC, cause and trap value. A hart identifier register can be read and always reads as zero. The unit only decides whether an access is legal and produces the result. Taking the trap, vectoring and delegation are left to the surrounding core.

Top module: `cru_access_unit`

## Requirements
- R1: Each access marked by `exec_i` at a rising clock edge produces its results at that same edge. `done_o` is high for exactly the following cycle. While `done_o` is low, `rd_we_o` and `illegal_o` are low.
- R2: Operation codes on `op_i`: 2'b01 replaces the register with the source, 2'b10 ORs the source into the register, and 2'b11 ANDs the register with the inverted source. Code 2'b00 is reserved and raises the illegal flag.
- R3: When `use_imm_i` is high, the source is `src_idx_i` zero-extended to 64 bits, and `src_val_i` is ignored.
- R4: The OR and AND-NOT operations leave the register untouched when `src_idx_i` is zero, in both the register form and the immediate form. The replace operation writes even when that field is zero.
- R5: For a legal access, `rd_val_o` is the register value from before the access and `rd_we_o` is high.
- R6: Address map: 0x300 status, 0x302 exception delegation, 0x305 trap vector base, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 trap value, 0xF14 hart identifier. The hart identifier always reads zero.
- R7: An access to any other address is illegal. An illegal access changes no register, keeps `rd_we_o` low, returns `rd_val_o` as zero and puts the instruction word, zero-extended, on `trap_info_o`.
- R8: Addresses with bits [11:10] equal to 2'b11 are read-only. A replace operation on such an address, or an OR or AND-NOT with a nonzero source field, is illegal. An OR or AND-NOT with a zero source field is a legal read.
- R9: Address bits [9:8] give the lowest privilege level allowed to access the register. The access is illegal when `priv_i` (0 is user, 3 is machine) is below that level.
- R10: After reset every stored register is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Access strobe, one cycle per instruction |
| op_i | input | 2 | Operation code |
| addr_i | input | 12 | Control register address |
| src_idx_i | input | 5 | Source register index, or the immediate in immediate form |
| use_imm_i | input | 1 | Selects the immediate form |
| src_val_i | input | 64 | Value of the source general register |
| priv_i | input | 2 | Current privilege level |
| insn_i | input | 32 | Raw instruction word, reported on a trap |
| done_o | output | 1 | Result valid, one cycle after the strobe |
| rd_we_o | output | 1 | Destination write-back enable |
| rd_val_o | output | 64 | Register value from before the access |
| illegal_o | output | 1 | Illegal-instruction trap request |
| trap_info_o | output | 64 | Zero-extended instruction word on a trap |

## Verification
All results are registered once, so `done_o`, `rd_we_o`, `rd_val_o`, `illegal_o` and `trap_info_o` for an access become valid at the clock edge that samples `exec_i`. A register update from that access is first visible to the access after it. The bench drives each strobe on a falling edge, drops it on the next falling edge, and reads the outputs there, half a cycle after the capturing edge. It then checks that `done_o` has fallen one cycle later. Stored contents are observed only through later accesses that are legal reads (an OR with a zero source field), so every check of "unchanged" or "updated" is made one access after the stimulus.

// File: rtl/cru_pkg.sv
package cru_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } cr_op_e;

   localparam int unsigned ADDR_W   = 12;
   localparam int unsigned NUM_RW   = 7;
   localparam logic [ADDR_W-1:0] ADDR_HARTID = 12'hF14;

   // storage slot -> address; slot order is internal only
   function automatic logic [ADDR_W-1:0] rw_addr(input int unsigned slot);
      case (slot)
         0:       rw_addr = 12'h300;
         1:       rw_addr = 12'h302;
         2:       rw_addr = 12'h305;
         3:       rw_addr = 12'h340;
         4:       rw_addr = 12'h341;
         5:       rw_addr = 12'h342;
         6:       rw_addr = 12'h343;
         default: rw_addr = 12'h000;
      endcase
   endfunction

endpackage

// File: rtl/cru_decode.sv
module cru_decode import cru_pkg::*; #(
   parameter int unsigned NREG = NUM_RW
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        priv_i,
   input  cr_op_e            op_i,
   input  logic              wr_attempt_i,
   output logic [NREG-1:0]   sel_o,
   output logic              hid_hit_o,
   output logic              illegal_o
);

   localparam int unsigned RO_HI   = ADDR_W - 1;
   localparam int unsigned RO_LO   = ADDR_W - 2;
   localparam int unsigned PRIV_HI = ADDR_W - 3;
   localparam int unsigned PRIV_LO = ADDR_W - 4;

   logic known;
   logic read_only;
   logic priv_ok;

   for (genvar g = 0; g < NREG; g++) begin : g_match
      assign sel_o[g] = (addr_i == rw_addr(g));
   end

   assign hid_hit_o = (addr_i == ADDR_HARTID);
   assign known     = (|sel_o) | hid_hit_o;
   assign read_only = (addr_i[RO_HI:RO_LO] == 2'b11);
   assign priv_ok   = (priv_i >= addr_i[PRIV_HI:PRIV_LO]);

   assign illegal_o = ~known
                    | ~priv_ok
                    | (read_only & wr_attempt_i)
                    | (op_i == OP_NONE);

endmodule

// File: rtl/cru_alu.sv
module cru_alu import cru_pkg::*; #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IMM_W = 5
) (
   input  cr_op_e            op_i,
   input  logic              use_imm_i,
   input  logic [IMM_W-1:0]  src_idx_i,
   input  logic [XLEN-1:0]   src_val_i,
   input  logic [XLEN-1:0]   old_i,
   output logic [XLEN-1:0]   new_o,
   output logic              wr_attempt_o
);

   logic [XLEN-1:0] src;

   assign src = use_imm_i ? XLEN'(src_idx_i) : src_val_i;

   always_comb begin
      unique case (op_i)
         OP_WRITE: new_o = src;
         OP_SET:   new_o = old_i | src;
         OP_CLEAR: new_o = old_i & ~src;
         default:  new_o = old_i;
      endcase
   end

   // the index field (immediate or register number) gates set/clear writes
   always_comb begin
      unique case (op_i)
         OP_WRITE:         wr_attempt_o = 1'b1;
         OP_SET, OP_CLEAR: wr_attempt_o = (src_idx_i != '0);
         default:          wr_attempt_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cru_regfile.sv
module cru_regfile #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned NREG = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NREG-1:0]      wen_i,
   input  logic [XLEN-1:0]      wdata_i,
   input  logic [NREG-1:0]      sel_i,
   output logic [XLEN-1:0]      rdata_o,
   output logic [NREG*XLEN-1:0] flat_o
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wen_i[g])
            q <= wdata_i;
      end
      assign flat_o[g*XLEN +: XLEN] = q;
   end

   // unselected or unknown addresses read as zero
   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel_i[i])
            rdata_o = rdata_o | flat_o[i*XLEN +: XLEN];
      end
   end

endmodule

// File: rtl/cru_access_unit.sv
module cru_access_unit import cru_pkg::*; #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned IMM_W  = 5,
   parameter int unsigned INSN_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [IMM_W-1:0]  src_idx_i,
   input  logic              use_imm_i,
   input  logic [XLEN-1:0]   src_val_i,
   input  logic [1:0]        priv_i,
   input  logic [INSN_W-1:0] insn_i,
   output logic              done_o,
   output logic              rd_we_o,
   output logic [XLEN-1:0]   rd_val_o,
   output logic              illegal_o,
   output logic [XLEN-1:0]   trap_info_o
);

   localparam int unsigned FLAT_W = NUM_RW * XLEN;

   if (XLEN < INSN_W) begin : g_bad_xlen
      $error("XLEN must hold the instruction word");
   end
   if (IMM_W == 0 || IMM_W > XLEN) begin : g_bad_imm
      $error("IMM_W out of range");
   end

   cr_op_e              op;
   logic [NUM_RW-1:0]   sel;
   logic [NUM_RW-1:0]   wen;
   logic                hid_hit;
   logic                illegal_d;
   logic                wr_attempt;
   logic [XLEN-1:0]     old_val;
   logic [XLEN-1:0]     new_val;
   logic [FLAT_W-1:0]   reg_flat;
   logic                commit;

   assign op = cr_op_e'(op_i);

   cru_decode #(.NREG(NUM_RW)) u_dec (
      .addr_i       (addr_i),
      .priv_i       (priv_i),
      .op_i         (op),
      .wr_attempt_i (wr_attempt),
      .sel_o        (sel),
      .hid_hit_o    (hid_hit),
      .illegal_o    (illegal_d)
   );

   cru_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
      .op_i         (op),
      .use_imm_i    (use_imm_i),
      .src_idx_i    (src_idx_i),
      .src_val_i    (src_val_i),
      .old_i        (old_val),
      .new_o        (new_val),
      .wr_attempt_o (wr_attempt)
   );

   assign commit = exec_i & ~illegal_d & wr_attempt;
   assign wen    = sel & {NUM_RW{commit}};

   cru_regfile #(.XLEN(XLEN), .NREG(NUM_RW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen_i   (wen),
      .wdata_i (new_val),
      .sel_i   (sel),
      .rdata_o (old_val),
      .flat_o  (reg_flat)
   );

   // hart identifier has no storage: it reads through the zero default
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         rd_we_o     <= 1'b0;
         rd_val_o    <= '0;
         illegal_o   <= 1'b0;
         trap_info_o <= '0;
      end else begin
         done_o      <= exec_i;
         rd_we_o     <= exec_i & ~illegal_d;
         illegal_o   <= exec_i & illegal_d;
         rd_val_o    <= (exec_i & ~illegal_d & ~hid_hit) ? old_val : '0;
         trap_info_o <= (exec_i & illegal_d) ? XLEN'(insn_i) : '0;
      end
   end

endmodule

// File: rtl/cru_checker.sv
module cru_checker #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned IMM_W  = 5,
   parameter int unsigned FLAT_W = 448
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_i,
   input logic [1:0]        op_i,
   input logic [11:0]       addr_i,
   input logic [IMM_W-1:0]  src_idx_i,
   input logic [1:0]        priv_i,
   input logic              done_o,
   input logic              rd_we_o,
   input logic              illegal_o,
   input logic [XLEN-1:0]   rd_val_o,
   input logic              illegal_d,
   input logic [FLAT_W-1:0] reg_flat
);

   AST_DONE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(exec_i)); // R1

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!rd_we_o && !illegal_o)); // R1

   AST_ZERO_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i[1] && src_idx_i == '0) |=> $stable(reg_flat)); // R4

   AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && illegal_d) |=> $stable(reg_flat)); // R7

   AST_TRAP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && illegal_o) |-> !rd_we_o); // R7

   AST_HARTID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && addr_i == 12'hF14 && !illegal_d) |=> (rd_val_o == '0)); // R6

   AST_RO_WRITE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && addr_i[11:10] == 2'b11 && op_i == 2'b01) |=> illegal_o); // R8

   AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && priv_i < addr_i[9:8]) |=> illegal_o); // R9

endmodule

bind cru_access_unit cru_checker #(
   .XLEN   (XLEN),
   .IMM_W  (IMM_W),
   .FLAT_W (FLAT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exec_i    (exec_i),
   .op_i      (op_i),
   .addr_i    (addr_i),
   .src_idx_i (src_idx_i),
   .priv_i    (priv_i),
   .done_o    (done_o),
   .rd_we_o   (rd_we_o),
   .illegal_o (illegal_o),
   .rd_val_o  (rd_val_o),
   .illegal_d (illegal_d),
   .reg_flat  (reg_flat)
);

// File: tb/cru_access_unit_tb.sv
`timescale 1ns/1ps
module cru_access_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [11:0] addr_i = '0;
   logic [4:0]  src_idx_i = '0;
   logic        use_imm_i = 1'b0;
   logic [63:0] src_val_i = '0;
   logic [1:0]  priv_i = 2'd3;
   logic [31:0] insn_i = 32'h3404_A073;
   logic        done_o, rd_we_o, illegal_o;
   logic [63:0] rd_val_o, trap_info_o;

   int total = 0;
   int bad = 0;

   logic        g_done, g_we, g_ill;
   logic [63:0] g_rd, g_info;

   always #2.5 clk = ~clk;

   cru_access_unit u_dut (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .addr_i(addr_i),
      .src_idx_i(src_idx_i), .use_imm_i(use_imm_i), .src_val_i(src_val_i),
      .priv_i(priv_i), .insn_i(insn_i), .done_o(done_o), .rd_we_o(rd_we_o),
      .rd_val_o(rd_val_o), .illegal_o(illegal_o), .trap_info_o(trap_info_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic [1:0] op, input logic [11:0] addr,
                         input logic [4:0] idx, input logic [63:0] val,
                         input logic imm, input logic [1:0] priv);
      @(negedge clk);
      exec_i = 1'b1; op_i = op; addr_i = addr; src_idx_i = idx;
      src_val_i = val; use_imm_i = imm; priv_i = priv;
      @(negedge clk);
      exec_i = 1'b0;
      g_done = done_o; g_we = rd_we_o; g_ill = illegal_o;
      g_rd = rd_val_o; g_info = trap_info_o;
   endtask

   // legal read: OR with a zero index field
   task automatic peek(input logic [11:0] addr, output logic [63:0] v);
      access(2'b10, addr, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd3);
      v = g_rd;
   endtask

   function automatic logic [11:0] addr_of(input int i);
      case (i)
         0: return 12'h300; 1: return 12'h302; 2: return 12'h305;
         3: return 12'h340; 4: return 12'h341; 5: return 12'h342;
         default: return 12'h343;
      endcase
   endfunction

   function automatic logic [63:0] pat(input int i);
      return 64'hC0DE_0000_0000_0000 | (64'(i + 1) << (4 * i + 8)) | 64'(i + 1);
   endfunction

   task automatic t_reset();
      logic [63:0] v;
      chk("R10", "done after reset", 64'(done_o), 64'd0);
      chk("R10", "illegal after reset", 64'(illegal_o), 64'd0);
      chk("R10", "rd after reset", rd_val_o, 64'd0);
      for (int i = 0; i < 7; i++) begin
         peek(addr_of(i), v);
         chk("R10", "register zero after reset", v, 64'd0);
      end
   endtask

   task automatic t_map();
      logic [63:0] v;
      for (int i = 0; i < 7; i++) begin
         access(2'b01, addr_of(i), 5'd3, pat(i), 1'b0, 2'd3);
         chk("R5", "old value on first write", g_rd, 64'd0);
         chk("R5", "write-back enable", 64'(g_we), 64'd1);
      end
      for (int i = 0; i < 7; i++) begin
         peek(addr_of(i), v);
         chk("R6", "address map readback", v, pat(i));
      end
      access(2'b01, 12'h341, 5'd3, 64'h1234, 1'b0, 2'd3);
      chk("R5", "old value returned on replace", g_rd, pat(4));
   endtask

   task automatic t_set_clear();
      logic [63:0] v;
      access(2'b01, 12'h340, 5'd2, 64'hF0F0_0000_0000_00FF, 1'b0, 2'd3);
      access(2'b10, 12'h340, 5'd7, 64'h0F00_0000_0000_FF00, 1'b0, 2'd3);
      chk("R2", "set returns old", g_rd, 64'hF0F0_0000_0000_00FF);
      access(2'b11, 12'h340, 5'd9, 64'h00F0_0000_0000_0F0F, 1'b0, 2'd3);
      chk("R2", "set result", g_rd, 64'hFFF0_0000_0000_FFFF);
      peek(12'h340, v);
      chk("R2", "clear result", v, 64'hFF00_0000_0000_F0F0);
      access(2'b00, 12'h340, 5'd9, 64'hFFFF, 1'b0, 2'd3);
      chk("R2", "reserved code illegal", 64'(g_ill), 64'd1);
      peek(12'h340, v);
      chk("R2", "reserved code no change", v, 64'hFF00_0000_0000_F0F0);
   endtask

   task automatic t_imm();
      logic [63:0] v;
      access(2'b01, 12'h342, 5'd1, 64'h8000_0000_0000_0100, 1'b0, 2'd3);
      access(2'b10, 12'h342, 5'h13, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3);
      peek(12'h342, v);
      chk("R3", "immediate set", v, 64'h8000_0000_0000_0113);
      access(2'b11, 12'h342, 5'h03, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3);
      peek(12'h342, v);
      chk("R3", "immediate clear", v, 64'h8000_0000_0000_0110);
      access(2'b01, 12'h342, 5'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3);
      peek(12'h342, v);
      chk("R3", "immediate replace zero-extended", v, 64'h1F);
   endtask

   task automatic t_zero_src();
      logic [63:0] v;
      access(2'b01, 12'h343, 5'd5, 64'hDEAD_BEEF_0000_1234, 1'b0, 2'd3);
      access(2'b10, 12'h343, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd3);
      chk("R4", "zero-index set returns old", g_rd, 64'hDEAD_BEEF_0000_1234);
      access(2'b11, 12'h343, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd3);
      access(2'b11, 12'h343, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3);
      peek(12'h343, v);
      chk("R4", "zero source set/clear no write", v, 64'hDEAD_BEEF_0000_1234);
      access(2'b01, 12'h343, 5'd0, 64'd0, 1'b0, 2'd3);
      peek(12'h343, v);
      chk("R4", "replace with zero index writes", v, 64'd0);
   endtask

   task automatic t_unimpl();
      logic [63:0] v;
      insn_i = 32'h3010_9073;
      access(2'b01, 12'h301, 5'd1, 64'h55, 1'b0, 2'd3);
      chk("R7", "unknown address illegal", 64'(g_ill), 64'd1);
      chk("R7", "no write-back on trap", 64'(g_we), 64'd0);
      chk("R7", "trap info", g_info, 64'h3010_9073);
      chk("R7", "rd zero on trap", g_rd, 64'd0);
      access(2'b10, 12'h344, 5'd0, 64'h0, 1'b0, 2'd3);
      chk("R7", "unknown read illegal", 64'(g_ill), 64'd1);
      peek(12'h300, v);
      chk("R7", "neighbour unchanged", v, pat(0));
      chk("R7", "trap info cleared on legal", g_info, 64'd0);
   endtask

   task automatic t_readonly();
      access(2'b01, 12'hF14, 5'd1, 64'h7, 1'b0, 2'd3);
      chk("R8", "replace read-only illegal", 64'(g_ill), 64'd1);
      access(2'b10, 12'hF14, 5'd4, 64'h1, 1'b0, 2'd3);
      chk("R8", "set nonzero read-only illegal", 64'(g_ill), 64'd1);
      access(2'b10, 12'hF14, 5'd0, 64'hFF, 1'b0, 2'd3);
      chk("R8", "read-only read legal", 64'(g_ill), 64'd0);
      chk("R6", "hart id reads zero", g_rd, 64'd0);
      chk("R8", "read-only read write-back", 64'(g_we), 64'd1);
   endtask

   task automatic t_priv();
      logic [63:0] v;
      access(2'b10, 12'h340, 5'd0, 64'h0, 1'b0, 2'd0);
      chk("R9", "user access illegal", 64'(g_ill), 64'd1);
      access(2'b01, 12'h305, 5'd1, 64'h9999, 1'b0, 2'd1);
      chk("R9", "level-1 write illegal", 64'(g_ill), 64'd1);
      peek(12'h305, v);
      chk("R9", "no update without privilege", v, pat(2));
   endtask

   task automatic t_timing();
      access(2'b10, 12'h302, 5'd0, 64'h0, 1'b0, 2'd3);
      chk("R1", "done with result", 64'(g_done), 64'd1);
      @(negedge clk);
      chk("R1", "done one cycle only", 64'(done_o), 64'd0);
      chk("R1", "write-back low when idle", 64'(rd_we_o), 64'd0);
   endtask

   initial begin
      #(5.0 * 100000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_set_clear();
      t_imm();
      t_zero_src();
      t_unimpl();
      t_readonly();
      t_priv();
      t_timing();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule